// File: doc/BRIEF.md
# Shared Cluster Memory Port

This block is the single memory port that a cluster of sixteen processing elements shares. Each element presents an address register and a data register. When the array controller issues a load or store command, the port walks through the elements named in the command's active mask and serializes their accesses onto one 16-bit memory path. Each 32-bit word crosses that path as two back-to-back halfword beats, and the command picks the halfword order.

The command selects the address source. In direct mode one broadcast address serves every element. In indirect mode each element supplies its own address. Every element owns a private 64 KB region of the attached memory, and the element index picks the region. On a load, a per-element scoreboard bit marks the destination register busy until the assembled word is written back. While any work is outstanding, the port refuses new commands.

Top module: `cluster_mem_port`

## Requirements
- R1: After reset `busy`, `memEn`, `wbValid` and every bit of `peBusy` are low.
- R2: A command is accepted on a clock edge where `cmdValid` is high and `busy` is low. Starting in the next cycle, each element whose `cmdMask` bit is set is serviced in ascending index order, and elements whose bit is clear are skipped. Each serviced element gets two consecutive beats with `memEn` high, with no gap between elements. `memWe` is high for stores and low for loads.
- R3: In direct mode (`cmdIndirect`=0) every element uses `cmdAddr`. The halfword address is `memAddr = {element index (4 bits), byte address bits [15:2], beat (0 first, 1 second)}`.
- R4: In indirect mode (`cmdIndirect`=1) element i uses bits [16i+15:16i] of `peAddr`, placed into `memAddr` with the same layout as R3.
- R5: For a store, the word of element i is bits [32i+31:32i] of `peMdr`. With `cmdBigEnd`=0 the first beat carries bits [15:0] and the second carries [31:16]. With `cmdBigEnd`=1 the order is reversed.
- R6: For a load, `memRdata` is valid in the cycle after the beat's issue cycle. `wbValid` pulses for one cycle, three cycles after the element's first beat was issued, with `wbPe` set to the element index. `wbData` is {second beat, first beat} for `cmdBigEnd`=0 and {first beat, second beat} for `cmdBigEnd`=1.
- R7: On an accepted load, `peBusy[i]` is high for each masked element from the cycle after acceptance up to the cycle before its `wbValid` pulse. A store never sets `peBusy`.
- R8: `busy` is high from the cycle after acceptance until every beat has been issued and every load writeback has been made. A `cmdValid` presented while `busy` is high is ignored and causes no memory traffic.
- R9: An accepted command with an all-zero mask produces no memory traffic and leaves `busy` low.
- R10: While any `peBusy` bit is high, `pendReg` shows the destination register index of the load that set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command request |
| cmdStore | input | 1 | 1 = store, 0 = load |
| cmdIndirect | input | 1 | 1 = per-element address, 0 = broadcast address |
| cmdBigEnd | input | 1 | 1 = high half at the lower address |
| cmdAddr | input | 16 | Broadcast byte address |
| cmdReg | input | 6 | Destination register index of a load |
| cmdMask | input | 16 | Active-element mask |
| peAddr | input | 256 | Per-element address registers, 16 bits each |
| peMdr | input | 512 | Per-element data registers, 32 bits each |
| busy | output | 1 | Port occupied; commands refused |
| peBusy | output | 16 | Scoreboard: load outstanding per element |
| pendReg | output | 6 | Register index held busy by the scoreboard |
| memEn | output | 1 | Memory beat enable |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 19 | Halfword address {element, word, beat} |
| memWdata | output | 16 | Store beat data |
| memRdata | input | 16 | Load beat data, one cycle after issue |
| wbValid | output | 1 | Load word writeback strobe |
| wbPe | output | 4 | Element receiving the loaded word |
| wbData | output | 32 | Assembled loaded word |

## Verification
The bench runs sparse masks where the lowest and highest elements are both active with everything between them idle. A port that failed to skip inactive elements would show extra beats, and one with the wrong scan order would put the addresses out of sequence. The same data is written in one byte order and read back in the other, which catches a swapped halfword on either the store path or the assembly path. The bench also presents a command while a load is still draining, which catches a port that accepts early or corrupts the running operation. It checks that the scoreboard clears exactly as the writeback appears, which catches a bit that drops a cycle early or late, and it checks that an empty mask leaves the port idle.

// File: rtl/cmi_pkg.sv
package cmi_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic accept;   // command taken this cycle
    logic issue;    // a memory beat goes out this cycle
    logic beat;     // 0 = first halfword, 1 = second
    logic isStore;  // current command is a store
  } cmiStrobe_t;

endpackage

// File: rtl/cmi_ctrl.sv
module cmi_ctrl import cmi_pkg::*; #(
  parameter int NUM_PE    = 16,
  parameter int REG_IDX_W = 6,
  localparam int PE_IDX_W = $clog2(NUM_PE)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic                 cmdStore,
  input  logic [REG_IDX_W-1:0] cmdReg,
  input  logic [NUM_PE-1:0]    cmdMask,
  input  logic                 rdDone,
  input  logic [PE_IDX_W-1:0]  rdDonePe,
  input  logic                 pipeBusy,
  output cmiStrobe_t           strb,
  output logic [PE_IDX_W-1:0]  peSel,
  output logic                 busy,
  output logic [NUM_PE-1:0]    peBusy,
  output logic [REG_IDX_W-1:0] pendReg
);

  logic [NUM_PE-1:0]    remQ;
  logic [NUM_PE-1:0]    selOneHot;
  logic                 activeQ;
  logic                 beatQ;
  logic                 storeQ;
  logic [NUM_PE-1:0]    peBusyQ;
  logic [REG_IDX_W-1:0] pendRegQ;
  logic                 lastWord;

  // Lowest remaining element wins
  always_comb begin
    peSel = '0;
    for (int i = NUM_PE - 1; i >= 0; i--) begin
      if (remQ[i]) peSel = PE_IDX_W'(i);
    end
  end

  assign selOneHot = NUM_PE'(1) << peSel;
  assign lastWord  = (remQ & ~selOneHot) == '0;
  assign busy      = activeQ | pipeBusy | (|peBusyQ);

  assign strb.accept  = cmdValid & ~busy;
  assign strb.issue   = activeQ;
  assign strb.beat    = beatQ;
  assign strb.isStore = storeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remQ     <= '0;
      activeQ  <= 1'b0;
      beatQ    <= 1'b0;
      storeQ   <= 1'b0;
      peBusyQ  <= '0;
      pendRegQ <= '0;
    end else begin
      if (rdDone) peBusyQ[rdDonePe] <= 1'b0;
      if (strb.accept && (|cmdMask)) begin
        remQ    <= cmdMask;
        activeQ <= 1'b1;
        beatQ   <= 1'b0;
        storeQ  <= cmdStore;
        if (!cmdStore) begin
          peBusyQ  <= cmdMask;
          pendRegQ <= cmdReg;
        end
      end else if (activeQ) begin
        beatQ <= ~beatQ;
        if (beatQ) begin
          remQ <= remQ & ~selOneHot;
          if (lastWord) activeQ <= 1'b0;
        end
      end
    end
  end

  assign peBusy  = peBusyQ;
  assign pendReg = pendRegQ;

  AST_BEAT_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issue && !strb.beat) |=> (strb.issue && strb.beat && $stable(peSel))); // R2

  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issue && strb.beat) |=> (!strb.issue || (peSel > $past(peSel)))); // R2

  AST_STORE_NO_SCORE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issue && strb.isStore) |-> (peBusy == '0)); // R7

  AST_SCORE_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (|peBusy) |-> busy); // R8

endmodule

// File: rtl/cmi_datapath.sv
module cmi_datapath import cmi_pkg::*; #(
  parameter int NUM_PE = 16,
  parameter int ADDR_W = 16,
  parameter int WORD_W = 32,
  localparam int PE_IDX_W   = $clog2(NUM_PE),
  localparam int HALF_W     = WORD_W / 2,
  localparam int OFF_W      = $clog2(WORD_W / 8),
  localparam int MEM_ADDR_W = PE_IDX_W + ADDR_W - OFF_W + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  cmiStrobe_t               strb,
  input  logic [PE_IDX_W-1:0]      peSel,
  input  logic                     cmdIndirect,
  input  logic                     cmdBigEnd,
  input  logic [ADDR_W-1:0]        cmdAddr,
  input  logic [NUM_PE*ADDR_W-1:0] peAddr,
  input  logic [NUM_PE*WORD_W-1:0] peMdr,
  output logic                     memEn,
  output logic                     memWe,
  output logic [MEM_ADDR_W-1:0]    memAddr,
  output logic [HALF_W-1:0]        memWdata,
  input  logic [HALF_W-1:0]        memRdata,
  output logic                     rdDone,
  output logic [PE_IDX_W-1:0]      rdDonePe,
  output logic                     pipeBusy,
  output logic                     wbValid,
  output logic [PE_IDX_W-1:0]      wbPe,
  output logic [WORD_W-1:0]        wbData
);

  logic [ADDR_W-1:0]   dirAddrQ;
  logic                indirectQ;
  logic                bigEndQ;
  logic [ADDR_W-1:0]   selAddr;
  logic [WORD_W-1:0]   selWord;
  logic                rdValidQ;
  logic                rdBeatQ;
  logic [PE_IDX_W-1:0] rdPeQ;
  logic [HALF_W-1:0]   firstHalfQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirAddrQ  <= '0;
      indirectQ <= 1'b0;
      bigEndQ   <= 1'b0;
    end else if (strb.accept) begin
      dirAddrQ  <= cmdAddr;
      indirectQ <= cmdIndirect;
      bigEndQ   <= cmdBigEnd;
    end
  end

  assign selAddr  = indirectQ ? peAddr[peSel*ADDR_W +: ADDR_W] : dirAddrQ;
  assign selWord  = peMdr[peSel*WORD_W +: WORD_W];
  assign memEn    = strb.issue;
  assign memWe    = strb.issue & strb.isStore;
  assign memAddr  = {peSel, selAddr[ADDR_W-1:OFF_W], strb.beat};
  assign memWdata = (strb.beat ^ bigEndQ) ? selWord[WORD_W-1:HALF_W]
                                          : selWord[HALF_W-1:0];

  // Read return tracking: data is on memRdata one cycle after issue
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValidQ   <= 1'b0;
      rdBeatQ    <= 1'b0;
      rdPeQ      <= '0;
      firstHalfQ <= '0;
      wbValid    <= 1'b0;
      wbPe       <= '0;
      wbData     <= '0;
    end else begin
      rdValidQ <= strb.issue & ~strb.isStore;
      rdBeatQ  <= strb.beat;
      rdPeQ    <= peSel;
      wbValid  <= 1'b0;
      if (rdValidQ && !rdBeatQ) firstHalfQ <= memRdata;
      if (rdDone) begin
        wbValid <= 1'b1;
        wbPe    <= rdPeQ;
        wbData  <= bigEndQ ? {firstHalfQ, memRdata} : {memRdata, firstHalfQ};
      end
    end
  end

  assign rdDone   = rdValidQ & rdBeatQ;
  assign rdDonePe = rdPeQ;
  assign pipeBusy = rdValidQ;

  AST_WB_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |=> !wbValid); // R6

  AST_RD_PAIRED: assert property (@(posedge clk) disable iff (!rstN)
    (rdValidQ && !rdBeatQ) |=> (rdValidQ && rdBeatQ && rdPeQ == $past(rdPeQ))); // R6

endmodule

// File: rtl/cluster_mem_port.sv
module cluster_mem_port import cmi_pkg::*; #(
  parameter int NUM_PE    = 16,
  parameter int ADDR_W    = 16,
  parameter int WORD_W    = 32,
  parameter int REG_IDX_W = 6,
  localparam int PE_IDX_W   = $clog2(NUM_PE),
  localparam int HALF_W     = WORD_W / 2,
  localparam int MEM_ADDR_W = PE_IDX_W + ADDR_W - $clog2(WORD_W / 8) + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cmdValid,
  input  logic                     cmdStore,
  input  logic                     cmdIndirect,
  input  logic                     cmdBigEnd,
  input  logic [ADDR_W-1:0]        cmdAddr,
  input  logic [REG_IDX_W-1:0]     cmdReg,
  input  logic [NUM_PE-1:0]        cmdMask,
  input  logic [NUM_PE*ADDR_W-1:0] peAddr,
  input  logic [NUM_PE*WORD_W-1:0] peMdr,
  output logic                     busy,
  output logic [NUM_PE-1:0]        peBusy,
  output logic [REG_IDX_W-1:0]     pendReg,
  output logic                     memEn,
  output logic                     memWe,
  output logic [MEM_ADDR_W-1:0]    memAddr,
  output logic [HALF_W-1:0]        memWdata,
  input  logic [HALF_W-1:0]        memRdata,
  output logic                     wbValid,
  output logic [PE_IDX_W-1:0]      wbPe,
  output logic [WORD_W-1:0]        wbData
);

  cmiStrobe_t          strb;
  logic [PE_IDX_W-1:0] peSel;
  logic                rdDone;
  logic [PE_IDX_W-1:0] rdDonePe;
  logic                pipeBusy;

  cmi_ctrl #(.NUM_PE(NUM_PE), .REG_IDX_W(REG_IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdStore(cmdStore), .cmdReg(cmdReg), .cmdMask(cmdMask),
    .rdDone(rdDone), .rdDonePe(rdDonePe), .pipeBusy(pipeBusy),
    .strb(strb), .peSel(peSel), .busy(busy), .peBusy(peBusy), .pendReg(pendReg)
  );

  cmi_datapath #(.NUM_PE(NUM_PE), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .peSel(peSel),
    .cmdIndirect(cmdIndirect), .cmdBigEnd(cmdBigEnd), .cmdAddr(cmdAddr),
    .peAddr(peAddr), .peMdr(peMdr),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .rdDone(rdDone), .rdDonePe(rdDonePe), .pipeBusy(pipeBusy),
    .wbValid(wbValid), .wbPe(wbPe), .wbData(wbData)
  );

endmodule

// File: tb/cluster_mem_port_tb.sv
module cluster_mem_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPE = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0, cmdStore = 1'b0, cmdIndirect = 1'b0, cmdBigEnd = 1'b0;
  logic [15:0] cmdAddr = '0;
  logic [5:0]  cmdReg = '0;
  logic [15:0] cmdMask = '0;
  logic [NPE*16-1:0] peAddr;
  logic [NPE*32-1:0] peMdr;
  logic busy, memEn, memWe, wbValid;
  logic [15:0] peBusy;
  logic [5:0]  pendReg;
  logic [18:0] memAddr;
  logic [15:0] memWdata;
  logic [15:0] memRdata = '0;
  logic [3:0]  wbPe;
  logic [31:0] wbData;

  logic [15:0] pa [NPE];
  logic [31:0] pd [NPE];
  always_comb begin
    for (int i = 0; i < NPE; i++) begin
      peAddr[i*16 +: 16] = pa[i];
      peMdr[i*32 +: 32]  = pd[i];
    end
  end

  always #(CLK_PERIOD/2) clk = ~clk;

  cluster_mem_port u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdStore(cmdStore),
    .cmdIndirect(cmdIndirect), .cmdBigEnd(cmdBigEnd), .cmdAddr(cmdAddr),
    .cmdReg(cmdReg), .cmdMask(cmdMask), .peAddr(peAddr), .peMdr(peMdr),
    .busy(busy), .peBusy(peBusy), .pendReg(pendReg), .memEn(memEn), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .wbValid(wbValid), .wbPe(wbPe), .wbData(wbData)
  );

  // Environment memory: synchronous halfword array, sparse
  logic [15:0] simMem [int];
  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) simMem[int'(memAddr)] = memWdata;
      else memRdata <= simMem.exists(int'(memAddr)) ? simMem[int'(memAddr)] : 16'h0;
    end
  end

  // Reference model state
  typedef struct { bit we; int addr; logic [15:0] wd; string tag; } slot_t;
  typedef struct { int due; int pe; logic [31:0] data; } wb_t;
  slot_t slotQ[$];
  wb_t   wbQ[$];
  logic [15:0] refMem [int];
  int setC [NPE];
  int clrC [NPE];
  int pendExp = 0;
  int cyc = 0;
  bit modelBusy = 1'b0;
  string idleTag = "R2";
  int nChecks = 0, nErr = 0;

  function automatic logic [15:0] rdRef(int a);
    return refMem.exists(a) ? refMem[a] : 16'h0;
  endfunction

  function automatic int hAddr(int pe, logic [15:0] a, int beat);
    return (pe << 15) | (int'(a[15:2]) << 1) | beat;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  initial begin
    for (int i = 0; i < NPE; i++) begin setC[i] = 0; clrC[i] = 0; end
    wait (rstN);
    forever begin
      @(posedge clk);
      cyc++;
      #3;
      begin
        bit expBusy;
        logic [15:0] expPb;
        expBusy = (slotQ.size() > 0) || (wbQ.size() > 0 && wbQ[$].due > cyc);
        modelBusy = expBusy;
        chk(busy == expBusy, "R8", "busy", busy, expBusy);
        if (slotQ.size() > 0) begin
          slot_t s;
          s = slotQ.pop_front();
          chk(memEn == 1'b1, "R2", "memEn", memEn, 1);
          chk(memWe == s.we, "R2", "memWe", memWe, s.we);
          chk(int'(memAddr) == s.addr, s.tag, "memAddr", memAddr, s.addr);
          if (s.we) chk(memWdata == s.wd, "R5", "memWdata", memWdata, s.wd);
        end else begin
          chk(memEn == 1'b0, idleTag, "idle memEn", memEn, 0);
        end
        if (wbQ.size() > 0 && wbQ[0].due == cyc) begin
          wb_t w;
          w = wbQ.pop_front();
          chk(wbValid == 1'b1, "R6", "wbValid", wbValid, 1);
          chk(int'(wbPe) == w.pe, "R6", "wbPe", wbPe, w.pe);
          chk(wbData == w.data, "R6", "wbData", wbData, w.data);
        end else begin
          chk(wbValid == 1'b0, "R6", "stray wbValid", wbValid, 0);
        end
        for (int i = 0; i < NPE; i++) expPb[i] = (cyc >= setC[i]) && (cyc < clrC[i]);
        chk(peBusy == expPb, "R7", "peBusy", peBusy, expPb);
        if (expPb != 0) chk(int'(pendReg) == pendExp, "R10", "pendReg", pendReg, pendExp);
      end
    end
  end

  task automatic sendCmd(bit st, bit ind, bit big, logic [15:0] addr, int ri, logic [15:0] mask);
    int k;
    forever begin
      @(negedge clk);
      if (!modelBusy) break;
    end
    cmdValid = 1'b1; cmdStore = st; cmdIndirect = ind; cmdBigEnd = big;
    cmdAddr = addr; cmdReg = 6'(ri); cmdMask = mask;
    k = 0;
    for (int pe = 0; pe < NPE; pe++) begin
      if (mask[pe]) begin
        logic [15:0] a;
        int base;
        a = ind ? pa[pe] : addr;
        base = cyc + 1 + 2 * k;
        for (int b = 0; b < 2; b++) begin
          slot_t s;
          s.we = st;
          s.addr = hAddr(pe, a, b);
          s.wd = ((b == 1) ^ big) ? pd[pe][31:16] : pd[pe][15:0];
          s.tag = ind ? "R4" : "R3";
          slotQ.push_back(s);
          if (st) refMem[s.addr] = s.wd;
        end
        if (!st) begin
          wb_t w;
          logic [15:0] h0, h1;
          h0 = rdRef(hAddr(pe, a, 0));
          h1 = rdRef(hAddr(pe, a, 1));
          w.due = base + 3;
          w.pe = pe;
          w.data = big ? {h0, h1} : {h1, h0};
          wbQ.push_back(w);
          setC[pe] = cyc + 1;
          clrC[pe] = w.due;
          pendExp = ri;
        end
        k++;
      end
    end
    @(posedge clk);
    #1 cmdValid = 1'b0;
  endtask

  task automatic waitIdle();
    forever begin
      @(negedge clk);
      if (!modelBusy) break;
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nErr++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    for (int i = 0; i < NPE; i++) begin
      pa[i] = 16'(i * 64 + 16'h0100);
      pd[i] = 32'hA000_0000 | 32'(i * 32'h0001_0101) | 32'h0500_0000;
    end
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1", "reset busy", busy, 0);
    chk(memEn == 1'b0, "R1", "reset memEn", memEn, 0);
    chk(wbValid == 1'b0, "R1", "reset wbValid", wbValid, 0);
    chk(peBusy == 16'h0, "R1", "reset peBusy", peBusy, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R5: direct store, little-endian, all elements
    sendCmd(1, 0, 0, 16'h0010, 0, 16'hFFFF);
    // R3 R6 R7 R10: direct load, same order
    sendCmd(0, 0, 0, 16'h0010, 5, 16'hFFFF);
    // R6: same words loaded big-endian come back half-swapped
    sendCmd(0, 0, 1, 16'h0010, 9, 16'h00F0);
    // R4 R5: indirect big-endian store on a sparse mask
    sendCmd(1, 1, 1, 16'h0000, 0, 16'hA5A5);
    // R2 R4: ends-only mask, little-endian load
    sendCmd(0, 1, 0, 16'h0000, 33, 16'h8001);
    // R4 R6: indirect big-endian load of the sparse store
    sendCmd(0, 1, 1, 16'h0000, 63, 16'hA5A5);
    waitIdle();

    // R9: empty mask, no traffic, port stays idle
    idleTag = "R9";
    sendCmd(0, 0, 0, 16'h0040, 2, 16'h0000);
    repeat (4) @(negedge clk);
    idleTag = "R2";

    // R8: a request while a load drains is ignored
    sendCmd(0, 0, 0, 16'h0010, 7, 16'h0003);
    @(negedge clk);
    chk(busy == 1'b1, "R8", "busy during load", busy, 1);
    cmdValid = 1'b1; cmdStore = 1'b1; cmdMask = 16'hFFFF; cmdAddr = 16'h0200;
    @(negedge clk);
    cmdValid = 1'b0;
    idleTag = "R8";
    waitIdle();
    repeat (3) @(negedge clk);
    idleTag = "R2";

    // R2: back-to-back commands with a single element each
    sendCmd(1, 0, 1, 16'hFFFC, 0, 16'h4000);
    sendCmd(0, 0, 1, 16'hFFFC, 12, 16'h4000);
    sendCmd(0, 0, 0, 16'hFFFC, 13, 16'h4000);
    waitIdle();
    repeat (2) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule